// File: doc/BRIEF.md
# Serial Control Port for a Video/Audio Routing Switch

This block is the two-wire serial control port of a signal routing switch. It recovers START and STOP conditions and serial bits from the SCL and SDA lines, which it samples with a system clock much faster than the bus. It answers one device address, and one bit of that address comes from a board strap. A write transfer fills three 8-bit routing configuration registers, and their contents drive the downstream selector logic.

A read transfer returns two status bytes that are built from the source-detection inputs. The master can stop the read after the first byte by not acknowledging it. The block never drives SDA high. It only asserts an enable that pulls the line low, for acknowledges and for zero data bits.

Top module: `route_i2c_slave`

## Requirements
- R1: The device address is the 7-bit value 1001_00s, where s equals `addr_sel`. The byte after START is that address followed by a direction bit (0 = write, 1 = read). On a match the slave pulls SDA low during the ninth clock. On a mismatch the slave gives no acknowledge and ignores all traffic until the next START.
- R2: In a write, the data bytes are shifted in MSB first and each one is acknowledged. The first byte goes to `cfg_route1`, the second to `cfg_route2` and the third to `cfg_route3`. A register changes only when its own byte completes.
- R3: In a write, the fourth data byte and any later ones are not acknowledged and leave all three registers unchanged.
- R4: In a read, the first byte is {`det_grounded[3:0]`, 4'b0000}, with `det_grounded[3]` at bit 7. The second byte is `det_aspect[7:0]`, where the code of input n sits in bits [2n+1:2n]. Bytes are sent MSB first, and SDA changes only while SCL is low.
- R5: If the master does not acknowledge the first status byte, the slave releases SDA and keeps it released for the rest of the transfer.
- R6: Both status bytes are captured when the read address is acknowledged. Changes on the detection inputs after that point do not alter the bytes sent in the same transfer.
- R7: A repeated START at any point, including in the middle of a byte, aborts the transfer and restarts address decoding. Registers written by bytes that had already completed keep their new values, and a partial byte writes nothing.
- R8: Reset clears all three configuration registers to 0x00 and leaves SDA released.
- R9: A STOP returns the slave to idle with SDA released. Registers written before the STOP keep their values, and a following START is decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Digitised serial clock line |
| sda_i | input | 1 | Digitised serial data line (resolved bus level) |
| addr_sel | input | 1 | Strap that sets the variable address bit |
| det_grounded | input | 4 | Per-input separate-luma/chroma connection flags |
| det_aspect | input | 8 | Per-input 2-bit picture-format codes |
| sda_oe | output | 1 | When 1, SDA is pulled low |
| cfg_route1 | output | 8 | Configuration register 1 |
| cfg_route2 | output | 8 | Configuration register 2 |
| cfg_route3 | output | 8 | Configuration register 3 |

## Verification
The bench aims at the boundaries of the write byte count. A slave that acknowledged a fourth byte, or wrapped its register index, would corrupt `cfg_route1`. It also tests the strap-dependent address bit in both settings, since a design that ignored the strap would answer both addresses or neither. Repeated STARTs are issued after a completed byte and in the middle of one: a design that committed partial bytes, or kept decoding data after the restart, would show the wrong register values. On the read side, the bench changes the detection inputs between the address acknowledge and the data, and it clocks extra bits after a master not-acknowledge. These catch a live (uncaptured) status path and a slave that keeps driving SDA.

// File: rtl/route_i2c_pkg.sv
package route_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam logic [5:0] DEV_ADDR_HI = 6'b100100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } bus_state_t;
endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  // A bus condition only happens while SCL is steady high
  p_cond_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || bus_stop) |-> $past(scl_s));
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
  import route_i2c_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              addr_sel,
  input  logic [BYTE_W-1:0] stat_hi,
  input  logic [BYTE_W-1:0] stat_lo,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  bus_state_t        state_q, state_d;
  logic [2:0]        bit_q, bit_d;
  logic              full_q, full_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic [BYTE_W-1:0] snap_q, snap_d;
  logic              rw_q, rw_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              mack_q, mack_d;
  logic              oe_q, oe_d;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    full_d  = full_q;
    shift_d = shift_q;
    snap_d  = snap_q;
    rw_d    = rw_q;
    idx_d   = idx_q;
    mack_d  = mack_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    wr_idx  = idx_q;
    wr_data = shift_q;
    if (bus_start) begin
      state_d = ST_ADDR;
      bit_d   = 3'd0;
      full_d  = 1'b0;
      idx_d   = '0;
      oe_d    = 1'b0;
    end else if (bus_stop) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise && !full_q) begin
            shift_d = {shift_q[BYTE_W-2:0], sda_s};
            bit_d   = bit_q + 3'd1;
            if (bit_q == 3'd7) full_d = 1'b1;
          end else if (scl_fall && full_q) begin
            full_d = 1'b0;
            if (state_q == ST_ADDR) begin
              if (shift_q[BYTE_W-1:1] == {DEV_ADDR_HI, addr_sel}) begin
                rw_d    = shift_q[0];
                oe_d    = 1'b1;
                state_d = ST_ADDR_ACK;
              end else begin
                state_d = ST_SKIP;
              end
            end else if (idx_q < IDX_W'(NUM_REGS)) begin
              wr_en   = 1'b1;
              idx_d   = idx_q + IDX_W'(1);
              oe_d    = 1'b1;
              state_d = ST_WR_ACK;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_d = 3'd0;
            if (rw_q) begin
              shift_d = stat_hi;
              snap_d  = stat_lo;
              oe_d    = ~stat_hi[BYTE_W-1];
              state_d = ST_RD;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              oe_d    = 1'b0;
              mack_d  = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              shift_d = {shift_q[BYTE_W-2:0], 1'b0};
              oe_d    = ~shift_q[BYTE_W-2];
              bit_d   = bit_q + 3'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q && idx_q == '0) begin
              shift_d = snap_q;
              oe_d    = ~snap_q[BYTE_W-1];
              bit_d   = 3'd0;
              idx_d   = IDX_W'(1);
              state_d = ST_RD;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= 3'd0;
      full_q  <= 1'b0;
      shift_q <= '0;
      snap_q  <= '0;
      rw_q    <= 1'b0;
      idx_q   <= '0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      full_q  <= full_d;
      shift_q <= shift_d;
      snap_q  <= snap_d;
      rw_q    <= rw_d;
      idx_q   <= idx_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe = oe_q;

  // Slave starts pulling SDA only just after SCL went low
  p_drive_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !$past(scl_s));
  // Idle and skip states never hold the line
  p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_SKIP) |-> !oe_q);
  // No write past the last register
  p_wr_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));
  // STOP leaves the slave idle and released
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (state_q == ST_IDLE && !oe_q));
  // START restarts address decoding from bit zero
  p_start_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (state_q == ST_ADDR && bit_q == 3'd0 && !oe_q));
endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank
  import route_i2c_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [BYTE_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]  regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_o[g] <= '0;
      end else if (sel) begin
        regs_o[g] <= wr_data;
      end
    end

    // Register contents only move on a write strobe
    p_reg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_o[g]));
  end
endmodule

// File: rtl/route_i2c_slave.sv
module route_i2c_slave
  import route_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel,
  input  logic [3:0] det_grounded,
  input  logic [7:0] det_aspect,
  output logic       sda_oe,
  output logic [7:0] cfg_route1,
  output logic [7:0] cfg_route2,
  output logic [7:0] cfg_route3
);
  localparam int NUM_REGS = 3;
  localparam int IDX_W    = $clog2(NUM_REGS + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
  logic [BYTE_W-1:0] stat_hi, stat_lo;

  assign stat_hi = {det_grounded, 4'b0000};
  assign stat_lo = det_aspect;

  bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_xfer_fsm #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .addr_sel(addr_sel),
    .stat_hi(stat_hi), .stat_lo(stat_lo), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  ctrl_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(regs)
  );

  assign cfg_route1 = regs[0];
  assign cfg_route2 = regs[1];
  assign cfg_route3 = regs[2];
endmodule

// File: tb/test_route_i2c_slave.sv
module test_route_i2c_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, scl, sda_m, addr_sel, sda_oe;
  logic [3:0] det_g;
  logic [7:0] det_a;
  logic [7:0] cfg1, cfg2, cfg3;
  logic       sda_line;
  logic [7:0] mreg [3];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  route_i2c_slave i_route_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel(addr_sel), .det_grounded(det_g), .det_aspect(det_a),
    .sda_oe(sda_oe), .cfg_route1(cfg1), .cfg_route2(cfg2), .cfg_route3(cfg3)
  );

  function automatic logic [7:0] addr_byte(logic sel, logic rd);
    return {6'b100100, sel, rd};
  endfunction

  function automatic logic [7:0] stat_first(logic [3:0] g);
    return {g, 4'b0000};
  endfunction

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    chk(req, {24'd0, cfg1}, {24'd0, mreg[0]}, "cfg_route1");
    chk(req, {24'd0, cfg2}, {24'd0, mreg[1]}, "cfg_route2");
    chk(req, {24'd0, cfg3}, {24'd0, mreg[2]}, "cfg_route3");
  endtask

  task automatic b_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic b_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
    end
  endtask

  task automatic wr_byte(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    ack = ~sda_line;
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic rd_byte(logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
      b[i] = sda_line;
      wq(Q); scl = 1'b0; wq(Q);
    end
    sda_m = ~give_ack; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_txn(logic [7:0] addr, int n, logic match);
    logic ack;
    logic [7:0] d;
    b_start();
    wr_byte(addr, ack);
    chk("R1", {31'd0, ack}, {31'd0, match}, "address acknowledge");
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom());
      wr_byte(d, ack);
      if (match && k < 3) begin
        mreg[k] = d;
        chk("R2", {31'd0, ack}, 32'd1, "data acknowledge");
      end else if (match) begin
        chk("R3", {31'd0, ack}, 32'd0, "extra byte acknowledge");
      end else begin
        chk("R1", {31'd0, ack}, 32'd0, "ignored byte acknowledge");
      end
    end
    b_stop();
    chk_regs(match ? "R2" : "R1");
  endtask

  task automatic read_txn(logic two);
    logic ack;
    logic [7:0] b0, b1, e0, e1;
    e0 = stat_first(det_g);
    e1 = det_a;
    b_start();
    wr_byte(addr_byte(addr_sel, 1'b1), ack);
    chk("R1", {31'd0, ack}, 32'd1, "read address acknowledge");
    rd_byte(two, b0);
    chk("R4", {24'd0, b0}, {24'd0, e0}, "status byte 1");
    rd_byte(1'b0, b1);
    if (two) chk("R4", {24'd0, b1}, {24'd0, e1}, "status byte 2");
    else     chk("R5", {24'd0, b1}, 32'hFF, "line after master nack");
    b_stop();
    chk("R9", {31'd0, sda_oe}, 32'd0, "sda released after stop");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b0, b1;
    logic [3:0] g_old;
    logic [7:0] a_old;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; addr_sel = 1'b0;
    det_g = 4'h0; det_a = 8'h00;
    for (int k = 0; k < 3; k++) mreg[k] = 8'h00;
    wq(10); rst_n = 1'b1; wq(10);

    // R8: reset state
    chk_regs("R8");
    chk("R8", {31'd0, sda_oe}, 32'd0, "sda released after reset");

    // R2: full write with matching address, strap low
    write_txn(addr_byte(1'b0, 1'b0), 3, 1'b1);
    // R3: four data bytes, the last one rejected
    write_txn(addr_byte(1'b0, 1'b0), 4, 1'b1);
    // R1: strap high address while strap is low
    write_txn(addr_byte(1'b1, 1'b0), 3, 1'b0);
    // R1: strap high selects the other address
    addr_sel = 1'b1; wq(4);
    write_txn(addr_byte(1'b1, 1'b0), 3, 1'b1);
    write_txn(addr_byte(1'b0, 1'b0), 2, 1'b0);

    // R4: read both status bytes
    det_g = 4'b1010; det_a = 8'b11_10_01_00;
    read_txn(1'b1);
    // R5: master cuts the read after one byte
    det_g = 4'b0111; det_a = 8'h5C;
    read_txn(1'b0);

    // R6: detection inputs move after the address acknowledge
    det_g = 4'b1100; det_a = 8'h9B;
    g_old = det_g; a_old = det_a;
    b_start();
    wr_byte(addr_byte(1'b1, 1'b1), ack);
    det_g = 4'b0011; det_a = 8'h24;
    rd_byte(1'b1, b0);
    rd_byte(1'b0, b1);
    b_stop();
    chk("R6", {24'd0, b0}, {24'd0, stat_first(g_old)}, "captured status byte 1");
    chk("R6", {24'd0, b1}, {24'd0, a_old}, "captured status byte 2");

    // R7: repeated START in the middle of the second data byte
    b_start();
    wr_byte(addr_byte(1'b1, 1'b0), ack);
    wr_byte(8'h55, ack);
    mreg[0] = 8'h55;
    send_bits(8'h0F, 4);
    b_start();
    chk_regs("R7");
    wr_byte(addr_byte(1'b1, 1'b0), ack);
    chk("R7", {31'd0, ack}, 32'd1, "address after repeated start");
    wr_byte(8'hC3, ack); mreg[0] = 8'hC3;
    wr_byte(8'h3C, ack); mreg[1] = 8'h3C;
    b_stop();
    chk_regs("R7");

    // R9: STOP after one byte keeps the others; next START decodes
    b_start();
    wr_byte(addr_byte(1'b1, 1'b0), ack);
    wr_byte(8'hE1, ack); mreg[0] = 8'hE1;
    b_stop();
    chk_regs("R9");
    write_txn(addr_byte(1'b1, 1'b0), 3, 1'b1);

    // Random mix of transactions
    for (int t = 0; t < 24; t++) begin
      int op;
      logic [7:0] bad;
      op = int'($urandom() % 3);
      addr_sel = 1'($urandom()); wq(4);
      case (op)
        0: write_txn(addr_byte(addr_sel, 1'b0), 1 + int'($urandom() % 4), 1'b1);
        1: begin
          det_g = 4'($urandom()); det_a = 8'($urandom());
          read_txn(1'($urandom()));
        end
        default: begin
          bad = {7'($urandom()), 1'b0};
          if (bad[7:1] == {6'b100100, addr_sel}) bad[7] = ~bad[7];
          write_txn(bad, 3, 1'b0);
        end
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule